// File: doc/BRIEF.md
# Synchronous Receiver with Sync-Character Hunt

This block receives a clocked synchronous serial stream and finds word boundaries in it. Word boundaries are found by hunting for a programmable synchronous character. In search mode every received bit is shifted into a window. The most recent word-length bits are compared with the low bits of the sync character. When they match, the receiver switches to framed mode and raises a one-cycle hunt pulse. From then on it cuts the stream into fixed-length words. Each word may be followed by a parity bit.

Each framed word goes into a single receive buffer. Loading a word sets the buffer-full flag. It also updates a match flag, which says whether the word equals the sync character, and a parity-error flag. Software controls the block through a found/search control write and a strip enable. Writing zero to found/search forces the receiver back to hunting. With strip enabled, sync characters are dropped instead of being stored. A status read clears buffer-full.

Bits arrive with a one-cycle strobe, `rx_bit_en`, in the system clock domain. The strobe marks the rising edge of the receive clock. Words arrive least significant bit first.

Top module: `sync_hunt_rx`

## Requirements
- R1: A control write with `ctrl_fs`=0 puts the receiver in search mode, and `found` reads 0 from the next cycle. No word is loaded while searching. A control write with `ctrl_fs`=1 enters framed mode directly, and the next strobed bit is bit 0 of a word.
- R2: In search mode each strobed bit is compared. `found` rises at the clock edge of the bit that makes the last `word_len` received bits equal `sync_char[word_len-1:0]`. In that window the earliest received bit is bit 0.
- R3: `hunt_irq` is high for exactly one cycle, at the edge where a hunt match sets `found`.
- R4: In framed mode a word is `word_len` data bits, received least significant first. When `par_en`=1 a parity bit follows them. The first word starts on the bit after the sync character, or after its parity bit when `par_en`=1. Words follow each other without gaps.
- R5: On each load, `match_flag` becomes 1 if the loaded word equals `sync_char[word_len-1:0]` and 0 otherwise. The parity bit plays no part in the comparison.
- R6: With `strip_en`=1 a word equal to the sync character is not loaded. `rx_word`, `buf_full`, `match_flag` and `par_err` keep their values.
- R7: With `strip_en`=0 a sync-character word is loaded like any other word and sets `buf_full`.
- R8: `stat_rd` clears `buf_full`. A load in the same cycle wins, so `buf_full` stays 1.
- R9: On each load, `par_err` is 1 when the parity bit disagrees with the data: even parity when `par_odd`=0, odd parity when `par_odd`=1. It is always 0 when `par_en`=0.
- R10: After reset the receiver is searching, and `found`, `hunt_irq`, `buf_full`, `match_flag`, `par_err` and `rx_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_en | input | 1 | One-cycle strobe: receive clock rising edge |
| rx_bit | input | 1 | Serial data, valid with `rx_bit_en` |
| sync_char | input | DATA_W | Synchronous character; low `word_len` bits used |
| word_len | input | LEN_W | Data bits per word, 1 to DATA_W |
| par_en | input | 1 | A parity bit follows each word |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| strip_en | input | 1 | Drop sync-character words |
| ctrl_wr | input | 1 | Control write strobe for found/search |
| ctrl_fs | input | 1 | Found/search value written by `ctrl_wr` |
| stat_rd | input | 1 | Status read strobe; clears buffer-full |
| rx_word | output | DATA_W | Receive buffer, right-aligned |
| buf_full | output | 1 | Receive buffer holds an unread word |
| match_flag | output | 1 | Last loaded word equals the sync character |
| par_err | output | 1 | Last loaded word had a parity error |
| found | output | 1 | Found/search state, 1 when framed |
| hunt_irq | output | 1 | One-cycle pulse on a hunt match |

## Verification
The status read and the load of a word can land on the same clock edge. One clears buffer-full and the other sets it. The bench provokes this by holding `stat_rd` during the strobe of the last bit of a word, parity bit included. At the following negative edge it requires `buf_full` to be 1 and `rx_word` to hold the new word. A lone read afterwards must then clear `buf_full`. The same kind of overlap between a control write and a hunt match is settled in favour of the write.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  // Framing state of the receiver
  typedef enum logic [1:0] {
    PH_SEARCH = 2'd0,  // hunting bit by bit for the sync character
    PH_SKIP   = 2'd1,  // discarding the parity bit of the sync character
    PH_FRAME  = 2'd2   // counting fixed-length words
  } rx_phase_e;

endpackage

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DATA_W-1:0] sync_char,
  output logic [DATA_W-1:0] win_cur,
  output logic [DATA_W-1:0] win_next,
  output logic              hit_cur,
  output logic              hit_next
);

  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] sr_d;
  logic [DATA_W-1:0] len_mask;
  logic [LEN_W-1:0]  drop;

  // New bits enter at the top, so after word_len shifts the first bit sits
  // at DATA_W-word_len; shifting right by that amount right-aligns the word.
  always_comb begin
    sr_d     = {bit_in, sr_q[DATA_W-1:1]};
    drop     = LEN_W'(DATA_W) - word_len;
    len_mask = ~({DATA_W{1'b1}} << word_len);
    win_cur  = (sr_q >> drop) & len_mask;
    win_next = (sr_d >> drop) & len_mask;
    hit_cur  = (win_cur  == (sync_char & len_mask));
    hit_next = (win_next == (sync_char & len_mask));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= sr_d;
    end
  end

  // R4: the newest bit lands at the top of the window
  assert_lsb_first_R4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sr_q[DATA_W-1] == $past(bit_in)));

endmodule

// File: rtl/sync_rx_framer.sv
module sync_rx_framer
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             par_en,
  input  logic [LEN_W-1:0] word_len,
  input  logic             hit_next,
  input  logic             ctrl_wr,
  input  logic             ctrl_fs,
  output logic             found,
  output logic             hunt_irq,
  output logic             data_slot,
  output logic             word_done
);

  rx_phase_e       phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic            last_slot;
  logic            fill_ok;

  always_comb begin
    last_slot = par_en ? (cnt_q == word_len) : (cnt_q == word_len - 1'b1);
    fill_ok   = (cnt_q >= word_len - 1'b1);
    data_slot = (phase_q == PH_SEARCH) || ((phase_q == PH_FRAME) && (cnt_q < word_len));
    word_done = bit_en && !ctrl_wr && (phase_q == PH_FRAME) && last_slot;
    found     = (phase_q != PH_SEARCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_SEARCH;
      cnt_q    <= '0;
      hunt_irq <= 1'b0;
    end else begin
      hunt_irq <= 1'b0;
      if (ctrl_wr) begin
        phase_q <= ctrl_fs ? PH_FRAME : PH_SEARCH;
        cnt_q   <= '0;
      end else if (bit_en) begin
        unique case (phase_q)
          PH_SEARCH: begin
            // In search, cnt_q counts bits since the hunt began (saturating)
            if (hit_next && fill_ok) begin
              phase_q  <= par_en ? PH_SKIP : PH_FRAME;
              cnt_q    <= '0;
              hunt_irq <= 1'b1;
            end else if (!fill_ok) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_SKIP: begin
            phase_q <= PH_FRAME;
            cnt_q   <= '0;
          end
          default: begin
            cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
          end
        endcase
      end
    end
  end

  // R1: a software write of zero forces search
  assert_sw_search_R1: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !ctrl_fs) |=> !found);

  // R3: the hunt pulse only accompanies entry to the found state
  assert_irq_with_found_R3: assert property (@(posedge clk) disable iff (rst)
    hunt_irq |-> found);

  // R3: the hunt pulse is a single cycle
  assert_irq_single_R3: assert property (@(posedge clk) disable iff (rst)
    hunt_irq |=> !hunt_irq);

  // R1: no word completes while searching
  assert_no_word_in_search_R1: assert property (@(posedge clk) disable iff (rst)
    !found |-> !word_done);

endmodule

// File: rtl/sync_rx_buffer.sv
module sync_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic [DATA_W-1:0] word_in,
  input  logic              word_is_sync,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              par_bit,
  input  logic              strip_en,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_word,
  output logic              buf_full,
  output logic              match_flag,
  output logic              par_err
);

  logic load;
  logic fault;

  always_comb begin
    load  = load_req && !(strip_en && word_is_sync);
    fault = par_en && ((^word_in ^ par_bit) != par_odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word    <= '0;
      buf_full   <= 1'b0;
      match_flag <= 1'b0;
      par_err    <= 1'b0;
    end else begin
      if (load) begin
        rx_word    <= word_in;
        match_flag <= word_is_sync;
        par_err    <= fault;
        buf_full   <= 1'b1;
      end else if (stat_rd) begin
        buf_full   <= 1'b0;
      end
    end
  end

  // R5: a loaded sync word raises the match flag
  assert_match_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    (load_req && word_is_sync && !strip_en) |=> match_flag);

  // R6: a stripped sync word leaves the buffer untouched
  assert_strip_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (load_req && word_is_sync && strip_en && !stat_rd) |=>
      ($stable(rx_word) && $stable(buf_full) && $stable(match_flag)));

  // R7, R8: a load sets buffer-full even against a status read
  assert_load_sets_full_R8: assert property (@(posedge clk) disable iff (rst)
    (load_req && !(strip_en && word_is_sync)) |=> buf_full);

  // R8: a lone status read clears buffer-full
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !load_req) |=> !buf_full);

  // R9: no parity error without parity
  assert_no_parity_R9: assert property (@(posedge clk) disable iff (rst)
    (load_req && !par_en && !(strip_en && word_is_sync)) |=> !par_err);

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
  parameter  int DATA_W = 8,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit_en,
  input  logic              rx_bit,
  input  logic [DATA_W-1:0] sync_char,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              strip_en,
  input  logic              ctrl_wr,
  input  logic              ctrl_fs,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_word,
  output logic              buf_full,
  output logic              match_flag,
  output logic              par_err,
  output logic              found,
  output logic              hunt_irq
);

  logic [DATA_W-1:0] win_cur;
  logic [DATA_W-1:0] win_next;
  logic              hit_cur;
  logic              hit_next;
  logic              data_slot;
  logic              word_done;
  logic              shift_en;
  logic [DATA_W-1:0] word_sel;
  logic              word_sync;

  // Parity slots do not shift, so with parity the word is the held window
  always_comb begin
    shift_en  = rx_bit_en && data_slot;
    word_sel  = par_en ? win_cur : win_next;
    word_sync = par_en ? hit_cur : hit_next;
  end

  sync_rx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .bit_in    (rx_bit),
    .word_len  (word_len),
    .sync_char (sync_char),
    .win_cur   (win_cur),
    .win_next  (win_next),
    .hit_cur   (hit_cur),
    .hit_next  (hit_next)
  );

  sync_rx_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) framer_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (rx_bit_en),
    .par_en    (par_en),
    .word_len  (word_len),
    .hit_next  (hit_next),
    .ctrl_wr   (ctrl_wr),
    .ctrl_fs   (ctrl_fs),
    .found     (found),
    .hunt_irq  (hunt_irq),
    .data_slot (data_slot),
    .word_done (word_done)
  );

  sync_rx_buffer #(.DATA_W(DATA_W)) buffer_i (
    .clk          (clk),
    .rst          (rst),
    .load_req     (word_done),
    .word_in      (word_sel),
    .word_is_sync (word_sync),
    .par_en       (par_en),
    .par_odd      (par_odd),
    .par_bit      (rx_bit),
    .strip_en     (strip_en),
    .stat_rd      (stat_rd),
    .rx_word      (rx_word),
    .buf_full     (buf_full),
    .match_flag   (match_flag),
    .par_err      (par_err)
  );

endmodule

// File: tb/sync_hunt_rx_tb.sv
module sync_hunt_rx_tb_top;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 4;
  localparam logic [DATA_W-1:0] SYNC = 8'h16;

  // Vector: len, par_en, par_odd, strip, data, pbit, exp_full, exp_match, exp_perr
  typedef struct packed {
    logic [3:0] len;
    logic       pe;
    logic       po;
    logic       strip;
    logic [7:0] data;
    logic       pbit;
    logic       ef;
    logic       em;
    logic       ep;
  } vec_t;

  localparam int NV = 9;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {4'd8, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8, 1'b0, 1'b0, 1'b0, 8'h16, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd8, 1'b0, 1'b0, 1'b1, 8'h16, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd8, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd8, 1'b1, 1'b1, 1'b0, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5, 1'b0, 1'b0, 1'b0, 8'h0B, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5, 1'b1, 1'b1, 1'b0, 8'h16, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd5, 1'b0, 1'b0, 1'b1, 8'h16, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst;
  logic              rx_bit_en, rx_bit;
  logic [DATA_W-1:0] sync_char;
  logic [LEN_W-1:0]  word_len;
  logic              par_en, par_odd, strip_en;
  logic              ctrl_wr, ctrl_fs, stat_rd;
  logic [DATA_W-1:0] rx_word;
  logic              buf_full, match_flag, par_err, found, hunt_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  sync_hunt_rx #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit),
    .sync_char(sync_char), .word_len(word_len), .par_en(par_en),
    .par_odd(par_odd), .strip_en(strip_en), .ctrl_wr(ctrl_wr),
    .ctrl_fs(ctrl_fs), .stat_rd(stat_rd), .rx_word(rx_word),
    .buf_full(buf_full), .match_flag(match_flag), .par_err(par_err),
    .found(found), .hunt_irq(hunt_irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One strobed bit; returns at the negedge after the capturing posedge
  task automatic send_bit(input logic b, input logic rd);
    @(negedge clk);
    rx_bit = b; rx_bit_en = 1'b1; stat_rd = rd;
    @(negedge clk);
    rx_bit_en = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic status_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic ctrl_write(input logic fs);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_fs = fs;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic hunt(input int len, input logic pe);
    ctrl_write(1'b0);
    check("R1", "found after search write", found, 0);
    for (int i = 0; i < len; i++) begin
      send_bit(SYNC[i], 1'b0);
      if (i == len - 2) check("R2", "found before last sync bit", found, 0);
    end
    check("R2", "found after sync", found, 1);
    check("R3", "hunt_irq on match", hunt_irq, 1);
    if (pe) send_bit(1'b0, 1'b0);   // parity bit of the sync character
    else @(negedge clk);
    check("R3", "hunt_irq one cycle", hunt_irq, 0);
  endtask

  task automatic send_word(input logic [7:0] d, input int len, input logic pe,
                           input logic pbit, input logic rd_last);
    for (int i = 0; i < len; i++) send_bit(d[i], rd_last && !pe && (i == len - 1));
    if (pe) send_bit(pbit, rd_last);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL all watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    logic [7:0] mask;
    vec_t v;
    rst = 1'b1; rx_bit_en = 0; rx_bit = 0; sync_char = SYNC; word_len = 4'd8;
    par_en = 0; par_odd = 0; strip_en = 0; ctrl_wr = 0; ctrl_fs = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", "found", found, 0);
    check("R10", "hunt_irq", hunt_irq, 0);
    check("R10", "buf_full", buf_full, 0);
    check("R10", "match_flag", match_flag, 0);
    check("R10", "par_err", par_err, 0);
    check("R10", "rx_word", rx_word, 0);

    prev = 8'h00;
    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VEC[i]);
      mask = 8'((9'd1 << v.len) - 9'd1);
      word_len = v.len; par_en = v.pe; par_odd = v.po; strip_en = v.strip;
      status_read();
      hunt(int'(v.len), v.pe);
      send_word(v.data, int'(v.len), v.pe, v.pbit, 1'b0);
      if (v.ef) prev = v.data & mask;
      check(v.strip ? "R6" : "R7", "buf_full", buf_full, v.ef);
      check("R5", "match_flag", match_flag, v.em);
      check("R9", "par_err", par_err, v.ep);
      check("R4", "rx_word", rx_word, prev);
    end

    // R1: non-matching stream while searching loads nothing
    word_len = 4'd8; par_en = 0; strip_en = 0;
    status_read();
    ctrl_write(1'b0);
    for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);
    check("R1", "found in search stream", found, 0);
    check("R1", "buf_full in search stream", buf_full, 0);

    // R1: software write of one frames immediately; R4 back-to-back words
    ctrl_write(1'b1);
    check("R1", "found after write one", found, 1);
    send_word(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    check("R1", "word after write one", rx_word, 8'h5A);
    send_word(8'hC3, 8, 1'b0, 1'b0, 1'b0);
    check("R4", "back-to-back word", rx_word, 8'hC3);

    // R8: status read on the load cycle, without and with parity
    send_word(8'h69, 8, 1'b0, 1'b0, 1'b1);
    check("R8", "buf_full read vs load", buf_full, 1);
    check("R8", "word on collision", rx_word, 8'h69);
    status_read();
    check("R8", "buf_full after lone read", buf_full, 0);
    par_en = 1'b1; par_odd = 1'b0;
    hunt(8, 1'b1);
    send_word(8'h81, 8, 1'b1, 1'b0, 1'b1);
    check("R8", "buf_full read vs parity load", buf_full, 1);
    check("R9", "even parity ok", par_err, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule